// File: doc/BRIEF.md
# Hierarchical State-Enable Register File

This block holds three tiers of access-enable registers: machine, hypervisor and supervisor. Each bit of a register allows code at a lower privilege level to touch one piece of extension state. A tier can only grant what the tier above it grants. A lower-tier bit reads as zero wherever the bit above is zero, and a write to it is dropped while that is so. In virtualized mode, the supervisor tier is also limited by the hypervisor tier.

Software reaches the registers through a single CSR port with address, write data, write enable and combinational read data. When the block runs as a 32-bit hart, each 64-bit machine and hypervisor register is split into a low half at its normal address and a high-half alias at its own address. A write to either half reaches the same storage. The block drives out the effective enable vectors of register 0 of every tier, for use by the decode and trap logic elsewhere.

Top module: `stateen_csr_file`

## Requirements
- R1: After synchronous reset, every register of every tier reads zero and all three enable outputs are zero.
- R2: In register 0 of the machine and hypervisor tiers, only bits 63, 62, 60, 59, 58, 57, 2, 1 and 0 are implemented (mask 64'hDE00_0000_0000_0007). The supervisor tier implements only bits 2, 1 and 0. All other bits read zero. Registers 1 to 3 of every tier read zero and ignore writes.
- R3: A hypervisor bit reads zero while the machine bit at the same position is zero, and a write to that bit is dropped while the machine bit is zero.
- R4: A supervisor bit reads zero, and is not written, while the machine bit at the same position is zero. When virt_mode is 1, the same holds where the hypervisor bit is zero.
- R5: While fp_present is 1, bit 1 of machine register 0 reads zero and cannot be set. It is therefore also zero in the lower tiers.
- R6: When rv32_mode is 1, a low address reads bits 31:0 and a high alias reads bits 63:32, both zero-extended. A write through the low address changes only bits 31:0, and a write through the alias changes only bits 63:32. The tier masking of R3 to R5 still applies.
- R7: When rv32_mode is 0, a low address reads and writes all 64 bits. The high alias addresses read zero and ignore writes.
- R8: The addresses are as follows. The machine tier sits at 0x30C with its alias at 0x31C. The hypervisor tier sits at 0x60C with its alias at 0x61C. The supervisor tier sits at 0x10C. Registers 1 to 3 sit at base+1 to base+3. Any other address reads zero and ignores writes.
- R9: m_en_o, h_en_o and s_en_o equal the readable value of register 0 of each tier. They change on the clock edge that takes a write.
- R10: A lower-tier bit that is hidden by a zero in the tier above keeps its stored value. It reads back again once the upper bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data (low 32 bits used for alias writes) |
| csr_we | input | 1 | Write enable |
| csr_rdata | output | 64 | Combinational read data |
| rv32_mode | input | 1 | 1 selects split halves with high aliases |
| virt_mode | input | 1 | 1 when accesses come from a virtual machine |
| fp_present | input | 1 | 1 when floating point is implemented |
| m_en_o | output | 64 | Effective machine enables, register 0 |
| h_en_o | output | 64 | Effective hypervisor enables, register 0 |
| s_en_o | output | 32 | Effective supervisor enables, register 0 |

## Verification
The bench tries to set hypervisor and supervisor bits while the machine bit above them is clear. It then opens the machine bit, to show that the dropped write left no mark. A design that merged the write before masking would then expose a stale one. The bench toggles virt_mode around a supervisor write, so a design that ignored the hypervisor limit would let bits through. It also writes each half through the 32-bit aliases, where a lane error would smear data into the wrong half. It sets fp_present, where a design that forgot the floating-point kill would show bit 1 set.

// File: rtl/stateen_pkg.sv
package stateen_pkg;
    localparam int XLEN  = 64;
    localparam int SLEN  = 32;
    localparam int HALF  = XLEN / 2;
    localparam int NREGS = 4;
    localparam int AW    = 12;

    localparam logic [XLEN-1:0] REG0_IMPL = 64'hDE00_0000_0000_0007;
    localparam int FCSR_POS = 1;

    localparam logic [AW-1:0] M_LO = 12'h30C;
    localparam logic [AW-1:0] M_HI = 12'h31C;
    localparam logic [AW-1:0] H_LO = 12'h60C;
    localparam logic [AW-1:0] H_HI = 12'h61C;
    localparam logic [AW-1:0] S_LO = 12'h10C;

    typedef enum logic [1:0] {TIER_NONE, TIER_M, TIER_H, TIER_S} tier_e;

    typedef struct packed {
        tier_e      tier;
        logic [1:0] idx;
        logic       upper;
    } csr_sel_t;

    function automatic logic [XLEN-1:0] impl_mask(input int idx);
        return (idx == 0) ? REG0_IMPL : '0;
    endfunction

    function automatic csr_sel_t decode(input logic [AW-1:0] a);
        csr_sel_t s;
        s = '{tier: TIER_NONE, idx: 2'd0, upper: 1'b0};
        for (int i = 0; i < NREGS; i++) begin
            if (a == M_LO + AW'(i)) s = '{tier: TIER_M, idx: 2'(i), upper: 1'b0};
            if (a == M_HI + AW'(i)) s = '{tier: TIER_M, idx: 2'(i), upper: 1'b1};
            if (a == H_LO + AW'(i)) s = '{tier: TIER_H, idx: 2'(i), upper: 1'b0};
            if (a == H_HI + AW'(i)) s = '{tier: TIER_H, idx: 2'(i), upper: 1'b1};
            if (a == S_LO + AW'(i)) s = '{tier: TIER_S, idx: 2'(i), upper: 1'b0};
        end
        return s;
    endfunction
endpackage

// File: rtl/stateen_decode.sv
module stateen_decode
    import stateen_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic [XLEN-1:0] wdata,
    input  logic            rv32,
    output csr_sel_t        sel,
    output logic            acc_ok,
    output logic [XLEN-1:0] lane,
    output logic [XLEN-1:0] wdata_al
);
    always_comb begin
        sel    = decode(addr);
        acc_ok = (sel.tier != TIER_NONE) && !(sel.upper && !rv32);
        if (!rv32) begin
            lane     = '1;
            wdata_al = wdata;
        end else if (sel.upper) begin
            lane     = {{HALF{1'b1}}, {HALF{1'b0}}};
            wdata_al = {wdata[HALF-1:0], {HALF{1'b0}}};
        end else begin
            lane     = {{HALF{1'b0}}, {HALF{1'b1}}};
            wdata_al = wdata;
        end
    end
endmodule

// File: rtl/stateen_tier.sv
module stateen_tier #(
    parameter int W = 64,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        we,
    input  logic [W-1:0]        wdata,
    input  logic [N-1:0][W-1:0] wmask,
    output logic [N-1:0][W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (we[i])
                q[i] <= (q[i] & ~wmask[i]) | (wdata & wmask[i]);
        end
    end
endmodule

// File: rtl/stateen_csr_file.sv
module stateen_csr_file
    import stateen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] csr_addr,
    input  logic [63:0] csr_wdata,
    input  logic        csr_we,
    output logic [63:0] csr_rdata,
    input  logic        rv32_mode,
    input  logic        virt_mode,
    input  logic        fp_present,
    output logic [63:0] m_en_o,
    output logic [63:0] h_en_o,
    output logic [31:0] s_en_o
);
    csr_sel_t        sel;
    logic            acc_ok;
    logic [XLEN-1:0] lane, wdata_al;

    stateen_decode u_dec (
        .addr(csr_addr), .wdata(csr_wdata), .rv32(rv32_mode),
        .sel(sel), .acc_ok(acc_ok), .lane(lane), .wdata_al(wdata_al)
    );

    logic [NREGS-1:0][XLEN-1:0] m_q, h_q, m_allow, h_allow, m_eff, h_eff, m_wm, h_wm;
    logic [NREGS-1:0][SLEN-1:0] s_q, s_allow, s_eff, s_wm;
    logic [NREGS-1:0]           m_we, h_we, s_we;

    for (genvar i = 0; i < NREGS; i++) begin : g_mask
        localparam logic [XLEN-1:0] IMPL = impl_mask(i);
        logic [XLEN-1:0] fp_kill;
        assign fp_kill    = (i == 0 && fp_present) ? (XLEN'(1) << FCSR_POS) : '0;
        assign m_allow[i] = IMPL & ~fp_kill;
        assign m_eff[i]   = m_q[i] & m_allow[i];
        assign h_allow[i] = IMPL & m_eff[i];
        assign h_eff[i]   = h_q[i] & h_allow[i];
        assign s_allow[i] = IMPL[SLEN-1:0] & m_eff[i][SLEN-1:0]
                          & (virt_mode ? h_eff[i][SLEN-1:0] : {SLEN{1'b1}});
        assign s_eff[i]   = s_q[i] & s_allow[i];

        assign m_wm[i] = m_allow[i] & lane;
        assign h_wm[i] = h_allow[i] & lane;
        assign s_wm[i] = s_allow[i];

        assign m_we[i] = csr_we && acc_ok && sel.tier == TIER_M && sel.idx == 2'(i);
        assign h_we[i] = csr_we && acc_ok && sel.tier == TIER_H && sel.idx == 2'(i);
        assign s_we[i] = csr_we && acc_ok && sel.tier == TIER_S && sel.idx == 2'(i);
    end

    stateen_tier #(.W(XLEN), .N(NREGS)) u_m (
        .clk(clk), .rst(rst), .we(m_we), .wdata(wdata_al), .wmask(m_wm), .q(m_q)
    );
    stateen_tier #(.W(XLEN), .N(NREGS)) u_h (
        .clk(clk), .rst(rst), .we(h_we), .wdata(wdata_al), .wmask(h_wm), .q(h_q)
    );
    stateen_tier #(.W(SLEN), .N(NREGS)) u_s (
        .clk(clk), .rst(rst), .we(s_we), .wdata(wdata_al[SLEN-1:0]), .wmask(s_wm), .q(s_q)
    );

    logic [XLEN-1:0] rsel;
    always_comb begin
        unique case (sel.tier)
            TIER_M:  rsel = m_eff[sel.idx];
            TIER_H:  rsel = h_eff[sel.idx];
            TIER_S:  rsel = {{(XLEN-SLEN){1'b0}}, s_eff[sel.idx]};
            default: rsel = '0;
        endcase
        if (!acc_ok)
            csr_rdata = '0;
        else if (!rv32_mode)
            csr_rdata = rsel;
        else if (sel.upper)
            csr_rdata = {{HALF{1'b0}}, rsel[XLEN-1:HALF]};
        else
            csr_rdata = {{HALF{1'b0}}, rsel[HALF-1:0]};
    end

    assign m_en_o = m_eff[0];
    assign h_en_o = h_eff[0];
    assign s_en_o = s_eff[0];
endmodule

// File: rtl/stateen_csr_file_chk.sv
module stateen_csr_file_chk (
    input logic        clk,
    input logic        rst,
    input logic [11:0] csr_addr,
    input logic [63:0] csr_wdata,
    input logic        csr_we,
    input logic [63:0] csr_rdata,
    input logic        rv32_mode,
    input logic        virt_mode,
    input logic        fp_present,
    input logic [63:0] m_en_o,
    input logic [63:0] h_en_o,
    input logic [31:0] s_en_o
);
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (m_en_o == 64'd0 && h_en_o == 64'd0 && s_en_o == 32'd0));

    assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (m_en_o & ~64'hDE00_0000_0000_0007) == 64'd0);

    assert_h_under_m_R3: assert property (@(posedge clk) disable iff (rst)
        (h_en_o & ~m_en_o) == 64'd0);

    assert_h_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == 12'h60C && !rv32_mode && !m_en_o[0] && !h_en_o[0]) |=> !h_en_o[0]);

    assert_s_under_m_R4: assert property (@(posedge clk) disable iff (rst)
        (s_en_o & ~m_en_o[31:0]) == 32'd0);

    assert_s_under_h_virt_R4: assert property (@(posedge clk) disable iff (rst)
        virt_mode |-> (s_en_o & ~h_en_o[31:0]) == 32'd0);

    assert_fcsr_kill_R5: assert property (@(posedge clk) disable iff (rst)
        fp_present |-> !m_en_o[1]);

    assert_alias_rv64_R7: assert property (@(posedge clk) disable iff (rst)
        (!rv32_mode && (csr_addr == 12'h31C || csr_addr == 12'h61C)) |-> csr_rdata == 64'd0);

    assert_rv32_upper_R6: assert property (@(posedge clk) disable iff (rst)
        rv32_mode |-> csr_rdata[63:32] == 32'd0);

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == 12'h300) |-> csr_rdata == 64'd0);
endmodule

bind stateen_csr_file stateen_csr_file_chk chk_i (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .rv32_mode(rv32_mode),
    .virt_mode(virt_mode), .fp_present(fp_present),
    .m_en_o(m_en_o), .h_en_o(h_en_o), .s_en_o(s_en_o)
);

// File: tb/stateen_csr_file_tb_top.sv
`timescale 1ns/1ps
module stateen_csr_file_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic        csr_we = 1'b0;
    logic [63:0] csr_rdata;
    logic        rv32_mode = 1'b0;
    logic        virt_mode = 1'b0;
    logic        fp_present = 1'b0;
    logic [63:0] m_en_o, h_en_o;
    logic [31:0] s_en_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [63:0] IMPL = 64'hDE00_0000_0000_0007;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    stateen_csr_file dut_i (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_rdata(csr_rdata), .rv32_mode(rv32_mode),
        .virt_mode(virt_mode), .fp_present(fp_present),
        .m_en_o(m_en_o), .h_en_o(h_en_o), .s_en_o(s_en_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [63:0] exp);
        csr_addr = a;
        #1;
        check(req, csr_rdata, exp);
    endtask

    task automatic t_reset();
        rd_check("R1 m0", 12'h30C, 64'd0);
        rd_check("R1 h0", 12'h60C, 64'd0);
        rd_check("R1 s0", 12'h10C, 64'd0);
        check("R1 outputs", m_en_o | h_en_o | {32'd0, s_en_o}, 64'd0);
    endtask

    task automatic t_impl_map();
        wr(12'h30C, ONES);
        rd_check("R2 m0 impl", 12'h30C, IMPL);
        check("R9 m_en_o", m_en_o, IMPL);
        wr(12'h30D, ONES);
        rd_check("R2 m1 zero", 12'h30D, 64'd0);
        wr(12'h60F, ONES);
        rd_check("R2 h3 zero", 12'h60F, 64'd0);
        wr(12'h123, ONES);
        rd_check("R8 unmapped", 12'h123, 64'd0);
        rd_check("R8 m0 intact", 12'h30C, IMPL);
    endtask

    task automatic t_fp();
        wr(12'h30C, 64'd0);
        fp_present = 1'b1;
        wr(12'h30C, ONES);
        rd_check("R5 fcsr killed", 12'h30C, IMPL & ~64'h2);
        check("R5 m_en_o", m_en_o, IMPL & ~64'h2);
        fp_present = 1'b0;
        wr(12'h30C, 64'd0);
    endtask

    task automatic t_hyp();
        wr(12'h30C, 64'h8000_0000_0000_0001);
        wr(12'h60C, ONES);
        rd_check("R3 h masked", 12'h60C, 64'h8000_0000_0000_0001);
        check("R9 h_en_o", h_en_o, 64'h8000_0000_0000_0001);
        wr(12'h30C, ONES);
        rd_check("R3 dropped", 12'h60C, 64'h8000_0000_0000_0001);
        wr(12'h30C, 64'h1);
        rd_check("R3 hidden", 12'h60C, 64'h1);
        wr(12'h30C, ONES);
        rd_check("R10 reappear", 12'h60C, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_sup();
        wr(12'h60C, 64'h1);
        wr(12'h10C, ONES);
        rd_check("R4 s nonvirt", 12'h10C, 64'h7);
        virt_mode = 1'b1;
        rd_check("R4 s virt", 12'h10C, 64'h1);
        check("R9 s_en_o", {32'd0, s_en_o}, 64'h1);
        wr(12'h10C, 64'd0);
        virt_mode = 1'b0;
        rd_check("R4 s virt write", 12'h10C, 64'h6);
    endtask

    task automatic t_rv32();
        wr(12'h30C, 64'd0);
        rd_check("R7 alias rv64", 12'h31C, 64'd0);
        wr(12'h31C, ONES);
        rd_check("R7 alias write ignored", 12'h30C, 64'd0);
        rv32_mode = 1'b1;
        wr(12'h31C, 64'h0000_0000_FFFF_FFFF);
        rd_check("R6 m hi", 12'h31C, 64'hDE00_0000);
        rd_check("R6 m lo", 12'h30C, 64'd0);
        wr(12'h30C, ONES);
        rd_check("R6 m lo write", 12'h30C, 64'h7);
        check("R6 m_en_o", m_en_o, IMPL);
        wr(12'h61C, 64'h0000_0000_FFFF_FFFF);
        rd_check("R6 h hi", 12'h61C, 64'hDE00_0000);
        rd_check("R6 h lo", 12'h60C, 64'h1);
        wr(12'h31C, 64'h8000_0000);
        rd_check("R6 h hi masked", 12'h61C, 64'h8000_0000);
        rv32_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_impl_map();
        t_fp();
        t_hyp();
        t_sup();
        t_rv32();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule